// File: doc/BRIEF.md
# Serial Register Write and Readback Front End

This block is the slave side of a four-wire serial port that feeds the register map of a multichannel converter. A master pulls the frame strobe low, clocks 24 bits in on the serial data line, then releases the strobe. The completed word is split into a 2-bit mode, a 6-bit address and a 16-bit data value. It is handed to the register bank as a single-cycle write pulse, and only if the frame held exactly 24 bits.

Readback takes two frames. A word whose mode bits are both zero names a register and writes nothing: the block raises a one-cycle read request carrying the register select. The bank returns the data in that same cycle. During the next frame, the block shifts that data out on the serial output while it takes in the new word. All pins are sampled into the system clock through synchronisers, and edge detection runs in the system clock domain. The serial clock therefore has to be several times slower than the system clock.

Top module: `serial_regif`

## Requirements
- R1: The word is taken MSB first, one bit per falling edge of `sclk_i` while `frame_n_i` is low. The fields are mode = bits 23:22, address = bits 21:16, data = bits 15:0.
- R2: A write is issued only when `frame_n_i` rises. `wr_valid` is high for exactly one cycle, on the third rising clock edge after the pin rises, and carries `wr_mode`, `wr_addr` and `wr_data`.
- R3: A frame with more than 24 falling `sclk_i` edges produces neither `wr_valid` nor `rd_req`.
- R4: A frame with fewer than 24 falling edges produces neither `wr_valid` nor `rd_req`.
- R5: After exactly 24 falling edges, `frame_n_i` may stay low for any time before it rises, and the frame is still accepted.
- R6: A 24-bit frame with mode 00 raises `rd_req` for one cycle, with the same timing as a write. `rd_sel` = bits 21:7, bits 6:0 are ignored, and no write is issued.
- R7: In the frame after a read request, `sdo_o` carries {8 zero bits, `rd_data` as sampled in the `rd_req` cycle}, MSB first. The first bit is present when the frame opens, and the output advances after each rising `sclk_i` edge that follows a falling edge, so that bit 23-k is valid at falling edge k.
- R8: The end of any frame, accepted or discarded, drops a pending readback. In a frame not directly preceded by an accepted read request, `sdo_o` stays 0.
- R9: After reset, `wr_valid`, `rd_req`, `sdo_o` and all field outputs are 0.
- R10: `wr_valid` and `rd_req` are never high together. The write fields change only with `wr_valid`, and `rd_sel` changes only with `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial readback data out |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_mode | output | 2 | Mode field of the write |
| wr_addr | output | 6 | Address field of the write |
| wr_data | output | 16 | Data field of the write |
| rd_req | output | 1 | One-cycle readback request |
| rd_sel | output | 15 | Register select of the readback |
| rd_data | input | 16 | Register contents, valid while rd_req is high |

## Verification
The pins pass through two synchroniser flops and an edge register, so a strobe is due on the third rising clock edge after `frame_n_i` rises. The bench changes the strobe on a falling clock edge and records `wr_valid` and `rd_req` at each of the next four falling edges. It expects the pattern 0,0,1,0, which pins the pulse to its cycle and its one-cycle width. A shift of the serial output follows a rising `sclk_i` edge after three clock cycles. The bench holds each serial clock phase for five cycles and reads `sdo_o` at the end of the high phase, just before it drives the falling edge the master would sample on.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;

   // Outcome of a frame, judged in the cycle its strobe is seen to rise
   typedef enum logic [1:0] {
      END_NONE  = 2'd0,
      END_DROP  = 2'd1,
      END_WRITE = 2'd2,
      END_READ  = 2'd3
   } frame_end_e;

endpackage

// File: rtl/serial_regif_sync.sv
module serial_regif_sync #(
   parameter int            W       = 3,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RST_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_regif_rx.sv
module serial_regif_rx
   import serial_regif_pkg::*;
#(
   parameter int FRAME_W = 24,
   parameter int MODE_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_stb,
   input  logic               close_stb,
   input  logic               bit_stb,
   input  logic               bit_val,
   output frame_end_e         end_kind,
   output logic [FRAME_W-1:0] word
);

   localparam int               CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);

   logic [CNT_W-1:0] cnt;
   logic             ovf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         ovf  <= 1'b0;
         word <= '0;
      end else if (open_stb) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (bit_stb) begin
         if (cnt == FULL) begin
            ovf <= 1'b1;
         end else begin
            word <= {word[FRAME_W-2:0], bit_val};
            cnt  <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      if (!close_stb)
         end_kind = END_NONE;
      else if (cnt != FULL || ovf)
         end_kind = END_DROP;
      else if (word[FRAME_W-1 -: MODE_W] == '0)
         end_kind = END_READ;
      else
         end_kind = END_WRITE;
   end

endmodule

// File: rtl/serial_regif_tx.sv
module serial_regif_tx #(
   parameter int FRAME_W = 24,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_stb,
   input  logic              load_stb,
   input  logic [DATA_W-1:0] load_val,
   input  logic              open_stb,
   input  logic              fall_stb,
   input  logic              rise_stb,
   output logic              sdo
);

   logic [FRAME_W-1:0] sr;
   logic [FRAME_W-1:0] load_word;
   logic               armed;

   generate
      if (DATA_W < FRAME_W) begin : g_pad
         assign load_word = {{(FRAME_W-DATA_W){1'b0}}, load_val};
      end else begin : g_full
         assign load_word = load_val[FRAME_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         armed <= 1'b0;
      end else begin
         if (clear_stb)
            sr <= '0;
         else if (load_stb)
            sr <= load_word;
         else if (rise_stb && armed)
            sr <= {sr[FRAME_W-2:0], 1'b0};

         if (open_stb)
            armed <= 1'b0;
         else if (fall_stb)
            armed <= 1'b1;
      end
   end

   assign sdo = sr[FRAME_W-1];

endmodule

// File: rtl/serial_regif.sv
module serial_regif
   import serial_regif_pkg::*;
#(
   parameter int FRAME_W  = 24,
   parameter int MODE_W   = 2,
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 16,
   parameter int SEL_LSB  = 7,
   parameter int SYNC_STG = 2,
   localparam int SEL_W   = FRAME_W - MODE_W - SEL_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              frame_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              wr_valid,
   output logic [MODE_W-1:0] wr_mode,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_req,
   output logic [SEL_W-1:0]  rd_sel,
   input  logic [DATA_W-1:0] rd_data
);

   generate
      if (MODE_W + ADDR_W + DATA_W != FRAME_W) begin : g_bad_fields
         $error("serial_regif: field widths must sum to FRAME_W");
      end
      if (SYNC_STG < 2) begin : g_bad_sync
         $error("serial_regif: SYNC_STG must be at least 2");
      end
      if (SEL_W < 1 || DATA_W > FRAME_W) begin : g_bad_sel
         $error("serial_regif: select or data width out of range");
      end
   endgenerate

   // synchronised pins: {frame strobe, serial clock, serial data}
   logic [2:0] pins_s;
   logic       frm_s, sck_s, sdi_s;
   logic       frm_q, sck_q;

   serial_regif_sync #(
      .W       (3),
      .STAGES  (SYNC_STG),
      .RST_VAL (3'b110)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({frame_n_i, sclk_i, sdi_i}),
      .dout (pins_s)
   );

   assign {frm_s, sck_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_q <= 1'b1;
         sck_q <= 1'b1;
      end else begin
         frm_q <= frm_s;
         sck_q <= sck_s;
      end
   end

   logic frm_fall, frm_rise, bit_stb, sck_rise_in;
   assign frm_fall    =  frm_q & ~frm_s;
   assign frm_rise    = ~frm_q &  frm_s;
   assign bit_stb     =  sck_q & ~sck_s & ~frm_s;
   assign sck_rise_in = ~sck_q &  sck_s & ~frm_s;

   frame_end_e         end_kind;
   logic [FRAME_W-1:0] word;

   serial_regif_rx #(
      .FRAME_W(FRAME_W),
      .MODE_W (MODE_W)
   ) rx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_stb (frm_fall),
      .close_stb(frm_rise),
      .bit_stb  (bit_stb),
      .bit_val  (sdi_s),
      .end_kind (end_kind),
      .word     (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_mode  <= '0;
         wr_addr  <= '0;
         wr_data  <= '0;
         rd_req   <= 1'b0;
         rd_sel   <= '0;
      end else begin
         wr_valid <= (end_kind == END_WRITE);
         rd_req   <= (end_kind == END_READ);
         if (end_kind == END_WRITE) begin
            wr_mode <= word[FRAME_W-1 -: MODE_W];
            wr_addr <= word[DATA_W +: ADDR_W];
            wr_data <= word[DATA_W-1:0];
         end
         if (end_kind == END_READ)
            rd_sel <= word[SEL_LSB +: SEL_W];
      end
   end

   serial_regif_tx #(
      .FRAME_W(FRAME_W),
      .DATA_W (DATA_W)
   ) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_stb(frm_rise),
      .load_stb (rd_req),
      .load_val (rd_data),
      .open_stb (frm_fall),
      .fall_stb (bit_stb),
      .rise_stb (sck_rise_in),
      .sdo      (sdo_o)
   );

endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk #(
   parameter int MODE_W = 2,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_rise,
   input logic              wr_valid,
   input logic [MODE_W-1:0] wr_mode,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_req,
   input logic [SEL_W-1:0]  rd_sel
);

   // R2: a write pulse lasts one cycle
   a_r2_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R2: a write only follows a seen rise of the frame strobe
   a_r2_wr_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(frm_rise));

   // R6: a read request lasts one cycle and follows a frame close
   a_r6_rd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   a_r6_rd_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> $past(frm_rise));

   // R6: a write never carries the readback mode
   a_r6_wr_mode_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_mode != '0));

   // R10: strobes are exclusive, fields move only with their strobe
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && rd_req));

   a_r10_wr_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(wr_addr) && $stable(wr_data) && $stable(wr_mode)) |-> wr_valid);

   a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_sel) |-> rd_req);

endmodule

bind serial_regif serial_regif_chk #(
   .MODE_W(MODE_W),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .SEL_W (SEL_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .frm_rise(frm_rise),
   .wr_valid(wr_valid),
   .wr_mode (wr_mode),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_req  (rd_req),
   .rd_sel  (rd_sel)
);

// File: tb/serial_regif_tb_top.sv
`timescale 1ns/1ps
module serial_regif_tb_top;

   localparam int PH = 5;           // system cycles per serial clock phase
   localparam int NV = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        frm_n = 1'b1;
   logic        sdi = 1'b0;
   logic        sdo;
   logic        wr_valid, rd_req;
   logic [1:0]  wr_mode;
   logic [5:0]  wr_addr;
   logic [15:0] wr_data;
   logic [14:0] rd_sel;
   logic [15:0] rd_data;

   int checks = 0;
   int failures = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [15:0] bank(input logic [14:0] s);
      return {s, 1'b1} ^ 16'h5A3C;
   endfunction

   assign rd_data = bank(rd_sel);

   serial_regif dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frm_n), .sdi_i(sdi),
      .sdo_o(sdo), .wr_valid(wr_valid), .wr_mode(wr_mode), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   always @(negedge clk) begin
      if (wr_valid) wr_cnt++;
      if (rd_req)   rd_cnt++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One frame: nedges falling edges, hold cycles before the strobe rises.
   // Returns the serial output seen before each falling edge and the
   // strobe values at the four falling clock edges after the rise.
   task automatic frame(input logic [23:0] w, input int nedges, input int hold,
                        output logic [23:0] miso, output logic [3:0] wtr,
                        output logic [3:0] rtr);
      miso = '0;
      @(negedge clk) frm_n = 1'b0;
      repeat (PH) @(negedge clk);
      for (int i = 0; i < nedges; i++) begin
         sdi = (i < 24) ? w[23-i] : 1'b0;
         repeat (PH) @(negedge clk);
         if (i < 24) miso[23-i] = sdo;
         sclk = 1'b0;
         repeat (PH) @(negedge clk);
         sclk = 1'b1;
      end
      repeat (hold) @(negedge clk);
      frm_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         wtr[k] = wr_valid;
         rtr[k] = rd_req;
      end
      repeat (8) @(negedge clk);
   endtask

   localparam logic [23:0] VW [NV] = '{
      {2'b11, 6'd5,  16'hABCD},
      {2'b01, 6'd63, 16'h0001},
      {2'b10, 6'd0,  16'hFFFF},
      {2'b11, 6'd42, 16'h1234},
      {2'b01, 6'd7,  16'h8000},
      {2'b10, 6'd21, 16'h5555}
   };
   localparam int VN [NV] = '{24, 24, 24, 25, 23, 24};
   localparam bit VOK [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [23:0] miso;
      logic [3:0]  wtr, rtr;
      logic [23:0] req_a, req_b;
      int          w0, r0;

      repeat (4) @(negedge clk);
      // R9: reset state
      chk("R9 wr_valid", {31'd0, wr_valid}, 32'd0);
      chk("R9 rd_req", {31'd0, rd_req}, 32'd0);
      chk("R9 sdo", {31'd0, sdo}, 32'd0);
      chk("R9 fields", {wr_mode, wr_addr, wr_data}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Vector table: R1 R2 R3 R4
      for (int v = 0; v < NV; v++) begin
         w0 = wr_cnt;
         frame(VW[v], VN[v], PH, miso, wtr, rtr);
         if (VOK[v]) begin
            chk($sformatf("R2 vec%0d pulse timing", v), {28'd0, wtr}, 32'h4);
            chk($sformatf("R1 vec%0d fields", v), {8'd0, wr_mode, wr_addr, wr_data}, {8'd0, VW[v]});
         end else begin
            chk($sformatf("R3/R4 vec%0d no write", v), {28'd0, wtr}, 32'h0);
            chk($sformatf("R3 R4 vec%0d no read", v), {28'd0, rtr}, 32'h0);
         end
         chk($sformatf("R2 vec%0d write count", v), wr_cnt - w0, VOK[v] ? 1 : 0);
         chk($sformatf("R8 vec%0d sdo idle", v), {8'd0, miso}, 32'd0);
      end

      // R5: long delay after the 24th edge
      frame({2'b01, 6'd33, 16'hC3A5}, 24, 60, miso, wtr, rtr);
      chk("R5 delayed close pulse", {28'd0, wtr}, 32'h4);
      chk("R5 delayed close data", {8'd0, wr_mode, wr_addr, wr_data}, {8'd0, 2'b01, 6'd33, 16'hC3A5});

      // R6: readback request, low bits ignored
      req_a = {2'b00, 15'h4B1D, 7'b1010101};
      w0 = wr_cnt; r0 = rd_cnt;
      frame(req_a, 24, PH, miso, wtr, rtr);
      chk("R6 rd_req timing", {28'd0, rtr}, 32'h4);
      chk("R6 no write", {28'd0, wtr}, 32'h0);
      chk("R6 rd_sel", {17'd0, rd_sel}, {17'd0, 15'h4B1D});
      chk("R10 write fields held", {8'd0, wr_mode, wr_addr, wr_data}, {8'd0, 2'b01, 6'd33, 16'hC3A5});
      chk("R6 counts", (wr_cnt - w0) * 16 + (rd_cnt - r0), 1);

      // R7: data returns in the next frame, which also writes
      frame({2'b11, 6'd9, 16'hBEEF}, 24, PH, miso, wtr, rtr);
      chk("R7 readback data", {8'd0, miso}, {16'd0, bank(15'h4B1D)});
      chk("R7 concurrent write", {8'd0, wr_mode, wr_addr, wr_data}, {8'd0, 2'b11, 6'd9, 16'hBEEF});
      chk("R10 rd_sel held", {17'd0, rd_sel}, {17'd0, 15'h4B1D});

      // R8: the frame after that returns zeros
      frame({2'b10, 6'd1, 16'h0F0F}, 24, PH, miso, wtr, rtr);
      chk("R8 sdo cleared", {8'd0, miso}, 32'd0);

      // R7: back-to-back requests, same bits 6:0 differ
      req_a = {2'b00, 15'h7FFF, 7'b0000000};
      req_b = {2'b00, 15'h0001, 7'b1111111};
      frame(req_a, 24, PH, miso, wtr, rtr);
      frame(req_b, 24, PH, miso, wtr, rtr);
      chk("R7 chained first data", {8'd0, miso}, {16'd0, bank(15'h7FFF)});
      chk("R6 chained second sel", {17'd0, rd_sel}, {17'd0, 15'h0001});
      frame({2'b01, 6'd2, 16'h0002}, 24, PH, miso, wtr, rtr);
      chk("R7 chained second data", {8'd0, miso}, {16'd0, bank(15'h0001)});

      // R8: a discarded frame drops the pending readback
      frame({2'b00, 15'h1234, 7'd0}, 24, PH, miso, wtr, rtr);
      frame({2'b11, 6'd3, 16'h3333}, 20, PH, miso, wtr, rtr);
      chk("R4 short frame no write", {28'd0, wtr}, 32'h0);
      frame({2'b11, 6'd4, 16'h4444}, 24, PH, miso, wtr, rtr);
      chk("R8 dropped readback", {8'd0, miso}, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule